// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block is a 16-bit output-compare unit. A compare value, loaded over an 8-bit bus as two bytes, is checked on every clock against one of two free-running timer counts; a select bit picks the timer. When the selected count first reaches the compare value, the block acts on a single output latch as the mode field directs: it sets the latch, clears it, toggles it or leaves it alone. In every active mode it also raises a sticky interrupt flag.

Two modes have no effect on the pin. One only raises the flag, for a timed software interrupt. The other also sends a one-clock strobe that resets whichever timer is selected and asks the converter to start a sample, so the compare value acts as a period register. The timers, the converter and the interrupt controller lie outside the block and connect through plain ports. The output-enable bit gates the latch onto the pin. Writing mode zero forces the latch low.

Top module: `tcmp_unit`

## Requirements
- R1: A write on `wr_lo` only stages the low byte. A write on `wr_hi` loads the compare value with the high byte from `wr_data` and the staged low byte, in one step. A staged low byte alone never changes the value being compared.
- R2: With `cfg_tsel`=0 the compare value is checked against `timer_a`. With `cfg_tsel`=1 it is checked against `timer_b`. The timer that is not selected never causes a match.
- R3: A match is the rising edge of equality. Equal values present before clock edge k act on the outputs after edge k+1. A timer that holds the compare value acts only once.
- R4: On a match, mode 4'b1000 sets the latch to 1, mode 4'b1001 clears it to 0 and mode 4'b0010 inverts it.
- R5: In mode 4'b1010 a match sets the flag and leaves the latch unchanged.
- R6: In mode 4'b1011 a match sets the flag, leaves the latch unchanged and drives `adc_start` high for exactly one clock. In that same clock, bit i of `timer_rst` is high for the selected timer (bit 0 is `timer_a`, bit 1 is `timer_b`).
- R7: Any other mode code, including 4'b0000, 4'b0101 and 4'b1111, makes a match do nothing: no flag, no latch change and no strobe.
- R8: The flag stays set until `flag_clr` is high at a clock edge. If a match sets the flag in the same cycle that `flag_clr` is high, the flag ends up set.
- R9: A configuration write with mode 4'b0000 forces the latch to 0. The latch stays 0 when a later mode is written, until a match changes it.
- R10: `pin_oe` follows the output-enable bit. `pin_o` shows the latch when output is enabled and 0 when it is not.
- R11: After reset the compare value, mode, select, enable, latch, flag and strobes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Stage `wr_data` as the compare low byte |
| wr_hi | input | 1 | Commit `wr_data` as the high byte together with the staged low byte |
| wr_data | input | 8 | Compare byte data |
| cfg_wr | input | 1 | Load mode, timer select and output enable |
| cfg_mode | input | 4 | Match action mode |
| cfg_tsel | input | 1 | Timer select (0 = timer_a, 1 = timer_b) |
| cfg_oe | input | 1 | Output enable |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| timer_a | input | 16 | Count of timer 0 |
| timer_b | input | 16 | Count of timer 1 |
| pin_o | output | 1 | Pin data (latch gated by the enable) |
| pin_oe | output | 1 | Pin drive enable; pad is tri-stated when low |
| irq_flag | output | 1 | Sticky match interrupt flag |
| adc_start | output | 1 | One-clock converter start strobe |
| timer_rst | output | 2 | One-clock reset strobe for the selected timer |

## Verification
The assertions check the cycle-level rules on every clock:
- A match event never lasts two clocks in a row.
- The flag rises only after a match, stays set until cleared, and set beats clear.
- The trigger strobe lasts one clock and follows a match in trigger mode.
- At most one timer reset bit is high at a time.
- The software-interrupt mode leaves the latch alone.
- A mode-zero write leaves the latch low.

The bench's scenarios are needed to show what depends on values:
- The action taken for each mode code and the disabled codes.
- That a staged low byte is not compared before its high byte.
- That the unselected timer is ignored.
- The exact two-edge latency.
- The enable gating of the pin.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 4'b0000,
    MODE_TOGGLE = 4'b0010,
    MODE_SET    = 4'b1000,
    MODE_CLR    = 4'b1001,
    MODE_SWI    = 4'b1010,
    MODE_TRIG   = 4'b1011
  } cmp_mode_e;

  // A mode is active when a match should raise the flag.
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    case (m)
      MODE_TOGGLE, MODE_SET, MODE_CLR, MODE_SWI, MODE_TRIG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Latch value after a match in mode m.
  function automatic logic latch_next(input logic [MODE_W-1:0] m, input logic cur);
    case (m)
      MODE_SET:    return 1'b1;
      MODE_CLR:    return 1'b0;
      MODE_TOGGLE: return ~cur;
      default:     return cur;
    endcase
  endfunction

  function automatic logic is_trig(input logic [MODE_W-1:0] m);
    return m == MODE_TRIG;
  endfunction

  function automatic logic is_clear_write(input logic wr, input logic [MODE_W-1:0] m);
    return wr && (m == MODE_OFF);
  endfunction
endpackage

// File: rtl/tcmp_cmpreg.sv
module tcmp_cmpreg #(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wr_data,
  output logic [CMP_W-1:0] cmp_val
);
  logic [BUS_W-1:0] lo_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage <= '0;
      cmp_val  <= '0;
    end else begin
      if (wr_lo) lo_stage <= wr_data;
      if (wr_hi) cmp_val  <= {wr_data, lo_stage};
    end
  end
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tsel,
  input  logic [CMP_W-1:0] timer_a,
  input  logic [CMP_W-1:0] timer_b,
  input  logic [CMP_W-1:0] cmp_val,
  output logic             eq_rise
);
  logic [CMP_W-1:0] sel_count;
  logic             eq_q;
  logic             eq_prev;

  assign sel_count = tsel ? timer_b : timer_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q    <= 1'b0;
      eq_prev <= 1'b0;
    end else begin
      eq_q    <= (sel_count == cmp_val);
      eq_prev <= eq_q;
    end
  end

  assign eq_rise = eq_q & ~eq_prev;
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              tsel_q,
  input  logic              match_evt,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              flag_clr,
  output logic              cmp_latch,
  output logic              irq_flag,
  output logic              trig_q,
  output logic              trig_sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_latch  <= 1'b0;
      irq_flag   <= 1'b0;
      trig_q     <= 1'b0;
      trig_sel_q <= 1'b0;
    end else begin
      if (is_clear_write(cfg_wr, cfg_mode))
        cmp_latch <= 1'b0;
      else if (match_evt)
        cmp_latch <= latch_next(mode_q, cmp_latch);

      if (match_evt)
        irq_flag <= 1'b1;
      else if (flag_clr)
        irq_flag <= 1'b0;

      trig_q     <= match_evt & is_trig(mode_q);
      trig_sel_q <= tsel_q;
    end
  end
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CMP_W = 2 * BUS_W,
  localparam int NUM_TMR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic               cfg_wr,
  input  logic [MODE_W-1:0]  cfg_mode,
  input  logic               cfg_tsel,
  input  logic               cfg_oe,
  input  logic               flag_clr,
  input  logic [CMP_W-1:0]   timer_a,
  input  logic [CMP_W-1:0]   timer_b,
  output logic               pin_o,
  output logic               pin_oe,
  output logic               irq_flag,
  output logic               adc_start,
  output logic [NUM_TMR-1:0] timer_rst
);
  logic [CMP_W-1:0]  cmp_val;
  logic [MODE_W-1:0] mode_q;
  logic              tsel_q;
  logic              oe_q;
  logic              eq_rise;
  logic              match_evt;
  logic              cmp_latch;
  logic              trig_q;
  logic              trig_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tsel_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= cfg_mode;
      tsel_q <= cfg_tsel;
      oe_q   <= cfg_oe;
    end
  end

  tcmp_cmpreg #(.BUS_W(BUS_W)) u_cmpreg (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .cmp_val(cmp_val)
  );

  tcmp_match #(.CMP_W(CMP_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tsel(tsel_q), .timer_a(timer_a),
    .timer_b(timer_b), .cmp_val(cmp_val), .eq_rise(eq_rise)
  );

  assign match_evt = eq_rise & mode_active(mode_q);

  tcmp_action u_action (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .tsel_q(tsel_q),
    .match_evt(match_evt), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .flag_clr(flag_clr), .cmp_latch(cmp_latch), .irq_flag(irq_flag),
    .trig_q(trig_q), .trig_sel_q(trig_sel_q)
  );

  assign adc_start = trig_q;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr_rst
    assign timer_rst[i] = trig_q & (trig_sel_q == 1'(i));
  end

  assign pin_oe = oe_q;
  assign pin_o  = oe_q & cmp_latch;
endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [3:0] cfg_mode,
  input logic [3:0] mode_q,
  input logic       match_evt,
  input logic       cmp_latch,
  input logic       irq_flag,
  input logic       flag_clr,
  input logic       adc_start,
  input logic [1:0] timer_rst
);
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> irq_flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !irq_flag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(match_evt));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(match_evt) && $past(mode_q) == 4'b1011));

  assert_rst_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(timer_rst));

  assert_swi_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q == 4'b1010 && !cfg_wr) |=> $stable(cmp_latch));

  assert_mode_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == 4'b0000) |=> !cmp_latch);
endmodule

bind tcmp_unit tcmp_unit_chk u_chk (.*);

// File: tb/tcmp_unit_bench.sv
module tcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic        cfg_tsel = 1'b0, cfg_oe = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] timer_a = 16'h0FF0, timer_b = 16'h0FF0;
  logic        pin_o, pin_oe, irq_flag, adc_start;
  logic [1:0]  timer_rst;

  int nchecks = 0;
  int nfail = 0;

  localparam logic [15:0] PARK = 16'h0FF0;

  always #4 clk = ~clk;

  tcmp_unit u_tcmp_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] m, input logic ts, input logic oe);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = m; cfg_tsel = ts; cfg_oe = oe;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wcmp(input logic [15:0] v);
    @(negedge clk); wr_lo = 1'b1; wr_data = v[7:0];
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic put(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); timer_a = a; timer_b = b;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic park();
    put(PARK, PARK);
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pin_o", pin_o, 0);
    chk("R11 pin_oe", pin_oe, 0);
    chk("R11 irq_flag", irq_flag, 0);
    chk("R11 adc_start", adc_start, 0);
    chk("R11 timer_rst", timer_rst, 0);
  endtask

  task automatic t_set_clear();
    cfg(4'b1000, 1'b0, 1'b1);
    wcmp(16'h1234);
    park();
    clr_flag();
    @(negedge clk); timer_a = 16'h1234;
    @(negedge clk);
    chk("R3 no action after first edge", pin_o, 0);
    @(negedge clk);
    chk("R4 set mode drives latch high", pin_o, 1);
    chk("R8 flag set by match", irq_flag, 1);
    clr_flag();
    chk("R8 flag cleared by flag_clr", irq_flag, 0);
    park();
    cfg(4'b1001, 1'b0, 1'b1);
    put(16'h1234, PARK);
    chk("R4 clear mode drives latch low", pin_o, 0);
    chk("R2 timer_a match with select 0", irq_flag, 1);
    park();
    clr_flag();
  endtask

  task automatic t_toggle_hold();
    cfg(4'b0010, 1'b0, 1'b1);
    put(16'h1234, PARK);
    chk("R4 toggle 0 to 1", pin_o, 1);
    repeat (4) @(negedge clk);
    chk("R3 held equality acts once", pin_o, 1);
    park();
    put(16'h1234, PARK);
    chk("R4 toggle 1 to 0", pin_o, 0);
    park();
    clr_flag();
  endtask

  task automatic t_byte_commit();
    cfg(4'b1000, 1'b0, 1'b1);
    @(negedge clk); wr_lo = 1'b1; wr_data = 8'h78;
    @(negedge clk); wr_lo = 1'b0;
    put(16'h1278, PARK);
    chk("R1 staged low byte not compared", irq_flag, 0);
    park();
    put(16'h1234, PARK);
    chk("R1 old value still compared", irq_flag, 1);
    park();
    clr_flag();
    @(negedge clk); wr_hi = 1'b1; wr_data = 8'h56;
    @(negedge clk); wr_hi = 1'b0;
    put(16'h1234, PARK);
    chk("R1 old value gone after commit", irq_flag, 0);
    park();
    put(16'h5678, PARK);
    chk("R1 committed value matches", irq_flag, 1);
    park();
    clr_flag();
  endtask

  task automatic t_select();
    cfg(4'b1000, 1'b0, 1'b1);
    put(16'h5678, PARK);
    park();
    clr_flag();
    cfg(4'b1001, 1'b1, 1'b1);
    put(16'h5678, PARK);
    chk("R2 unselected timer_a ignored", irq_flag, 0);
    chk("R2 latch kept when timer_a equal", pin_o, 1);
    park();
    put(PARK, 16'h5678);
    chk("R2 timer_b match with select 1", pin_o, 0);
    chk("R2 flag on timer_b match", irq_flag, 1);
    park();
    clr_flag();
  endtask

  task automatic t_swi();
    cfg(4'b1000, 1'b0, 1'b1);
    put(16'h5678, PARK);
    park();
    clr_flag();
    cfg(4'b1010, 1'b0, 1'b1);
    put(16'h5678, PARK);
    chk("R5 software mode leaves latch", pin_o, 1);
    chk("R5 software mode sets flag", irq_flag, 1);
    chk("R5 software mode no strobe", adc_start, 0);
    park();
    clr_flag();
  endtask

  task automatic t_trig();
    cfg(4'b1011, 1'b1, 1'b1);
    put(PARK, 16'h5678);
    chk("R6 adc_start pulse", adc_start, 1);
    chk("R6 timer_b reset strobe", timer_rst, 2'b10);
    chk("R6 latch unchanged", pin_o, 1);
    chk("R6 flag set", irq_flag, 1);
    @(negedge clk);
    chk("R6 adc_start one clock", adc_start, 0);
    chk("R6 reset strobe one clock", timer_rst, 2'b00);
    park();
    clr_flag();
    cfg(4'b1011, 1'b0, 1'b1);
    put(16'h5678, PARK);
    chk("R6 timer_a reset strobe", timer_rst, 2'b01);
    park();
    clr_flag();
  endtask

  task automatic t_disabled();
    cfg(4'b0101, 1'b0, 1'b1);
    put(16'h5678, PARK);
    chk("R7 mode 0101 no flag", irq_flag, 0);
    chk("R7 mode 0101 no latch change", pin_o, 1);
    chk("R7 mode 0101 no strobe", adc_start, 0);
    park();
    cfg(4'b1111, 1'b0, 1'b1);
    put(16'h5678, PARK);
    chk("R7 mode 1111 no flag", irq_flag, 0);
    chk("R7 mode 1111 no latch change", pin_o, 1);
    park();
  endtask

  task automatic t_oe();
    cfg(4'b0101, 1'b0, 1'b0);
    chk("R10 pin_oe low when disabled", pin_oe, 0);
    chk("R10 pin_o low when disabled", pin_o, 0);
    cfg(4'b0101, 1'b0, 1'b1);
    chk("R10 pin_oe high when enabled", pin_oe, 1);
    chk("R10 latch visible when enabled", pin_o, 1);
  endtask

  task automatic t_mode_zero();
    cfg(4'b0000, 1'b0, 1'b1);
    chk("R9 mode zero forces latch low", pin_o, 0);
    cfg(4'b1000, 1'b0, 1'b1);
    chk("R9 latch stays low after new mode", pin_o, 0);
  endtask

  task automatic t_set_wins();
    cfg(4'b1000, 1'b0, 1'b1);
    park();
    clr_flag();
    @(negedge clk); timer_a = 16'h5678;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R8 set beats clear", irq_flag, 1);
    clr_flag();
    chk("R8 clear after set", irq_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_toggle_hold();
    t_byte_commit();
    t_select();
    t_swi();
    t_trig();
    t_disabled();
    t_oe();
    t_mode_zero();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule